// File: doc/BRIEF.md
# Compare-Match Watchdog Interval Timer

This block is an 8-bit tick counter whose period is set by an equality compare against a programmable match value. It counts single-cycle strobes from an external prescaler overflow and ignores the system clock between them. The tick that finds the counter equal to the match value returns the counter to zero and raises an interrupt flag. The resulting interval is therefore the tick period times (match + 1).

A mode bit picks one of two uses. In interval mode the block is a periodic interrupt source. In watchdog mode each match also sends a one-cycle reset request to the chip's reset circuit. Software must restart the count before it reaches the match value, and it does this by writing a self-clearing clear bit in the mode register.

Software reaches the block over a byte-wide register bus. The match value is write-only and shares its address with the live counter, which is read-only. An interrupt acknowledge input clears the flag.

Top module: `wdog_match_timer`

## Requirements
- R1: After reset the counter reads 00h, the mode register reads 00h, the match value is FFh, and irq_o and cpu_rst_req_o are low. With that default match value and counting enabled, the first flag comes on the 256th tick.
- R2: While mode bit 7 (enable) is 1, each tick_i strobe adds 1 to the counter. While it is 0, ticks are ignored and the counter holds its value.
- R3: A tick that arrives while the counter equals the match value sets the counter to 0 and sets irq_o on the same clock edge, giving one flag every (match + 1) ticks. A match value of 0 flags on every tick.
- R4: Address 8Dh is the mode register, readable and writable over all 8 bits. A write to 8Eh loads the match value. A read of 8Eh returns the live counter. A read of any other address returns 00h. Read data is registered and appears on bus_rdata one cycle after the clock edge that samples bus_rd.
- R5: Writing 1 to mode bit 5 clears the counter on the following clock edge. On that same edge bit 5 returns to 0 with no further write.
- R6: When the clear from mode bit 5 and a tick fall on the same edge, the clear wins. The counter becomes 0 and no match is produced, even if the counter equalled the match value.
- R7: irq_o stays high until irq_ack_i is sampled high, which clears it. If a match occurs on the same edge as the acknowledge, irq_o stays high.
- R8: While mode bit 6 is 0 (interval mode), a match never asserts cpu_rst_req_o.
- R9: While mode bit 6 is 1 (watchdog mode), every match asserts cpu_rst_req_o for exactly one cycle, whether or not irq_o is already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_i | input | 1 | Prescaler overflow strobe, one cycle per tick |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_o | output | 1 | Interrupt request flag |
| cpu_rst_req_o | output | 1 | One-cycle CPU reset request |

## Verification
The in-RTL assertions check on every cycle the rules that hold at each edge:
- The counter holds while counting is disabled.
- A clear forces the counter to zero, and the counter wraps to zero after a match.
- The clear bit drops on its own.
- A reset request occurs only in watchdog mode and always comes with the flag set.
- An acknowledge with no match clears the flag.

Only the bench scenarios can show the behaviour that depends on history and on the register bus. That covers the full (match + 1) interval, including the 256-tick default period and the match-of-zero case. It also covers the address map and its shared address, the clear beating a tick on the same edge, and a reset pulse repeating while the flag is still pending.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Positions of the control bits in the mode register; software decodes these.
  localparam int MODE_EN_BIT  = 7;
  localparam int MODE_WD_BIT  = 6;
  localparam int MODE_CLR_BIT = 5;

  // Default register addresses.
  localparam logic [7:0] ADDR_MODE_DEF  = 8'h8D;
  localparam logic [7:0] ADDR_MATCH_DEF = 8'h8E;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_COUNT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(ADDR_MODE_DEF),
  parameter logic [ADDR_W-1:0] MATCH_ADDR = ADDR_W'(ADDR_MATCH_DEF),
  parameter logic [DATA_W-1:0] MATCH_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] match_val,
  output logic              en,
  output logic              wd_mode,
  output logic              clr
);
  logic [DATA_W-1:0] mode_q;
  logic              mode_wr;
  logic              match_wr;
  rd_sel_e           sel;
  logic [DATA_W-1:0] rd_mux;

  assign mode_wr  = wr && (addr == MODE_ADDR);
  assign match_wr = wr && (addr == MATCH_ADDR);

  always_comb begin
    if (addr == MODE_ADDR)       sel = SEL_MODE;
    else if (addr == MATCH_ADDR) sel = SEL_COUNT;
    else                         sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_MODE:  rd_mux = mode_q;
      SEL_COUNT: rd_mux = cnt;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      match_val <= MATCH_RESET;
      rdata     <= '0;
    end else begin
      if (mode_wr) begin
        mode_q <= wdata;
      end else begin
        mode_q[MODE_CLR_BIT] <= 1'b0;
      end
      if (match_wr) match_val <= wdata;
      if (rd)       rdata     <= rd_mux;
    end
  end

  assign en      = mode_q[MODE_EN_BIT];
  assign wd_mode = mode_q[MODE_WD_BIT];
  assign clr     = mode_q[MODE_CLR_BIT];

  // R5: without a fresh write of the bit, the clear lasts one cycle
  p_clr_self_r5: assert property (@(posedge clk) disable iff (rst)
    (clr && !(mode_wr && wdata[MODE_CLR_BIT])) |=> !clr);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic              tick,
  input  logic [DATA_W-1:0] match_val,
  output logic [DATA_W-1:0] cnt,
  output logic              hit
);
  logic step;

  assign step = en && tick && !clr;
  assign hit  = step && (cnt == match_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= hit ? '0 : cnt + 1'b1;
    end
  end

  // R2: counting disabled and no clear -> counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));
  // R6: a clear always leaves the counter at zero, tick or not
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R3: a match restarts the count
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == '0));
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic wd_mode,
  input  logic ack,
  output logic irq,
  output logic rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (hit)      irq <= 1'b1;
      else if (ack) irq <= 1'b0;
      rst_req <= hit && wd_mode;
    end
  end

  // R8: no reset request unless watchdog mode was selected
  p_rst_needs_wd_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(wd_mode));
  // R9: a reset request comes with the flag raised
  p_rst_with_flag_r9: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> irq);
  // R7: acknowledge without a match drops the flag
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && !hit) |=> !irq);
endmodule

// File: rtl/wdog_match_timer.sv
module wdog_match_timer
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(ADDR_MODE_DEF),
  parameter logic [ADDR_W-1:0] MATCH_ADDR = ADDR_W'(ADDR_MATCH_DEF),
  parameter logic [DATA_W-1:0] MATCH_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic              cpu_rst_req_o
);
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] match_val;
  logic              en;
  logic              wd_mode;
  logic              clr;
  logic              hit;

  wdt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR),
    .MATCH_ADDR(MATCH_ADDR), .MATCH_RESET(MATCH_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cnt(cnt), .rdata(bus_rdata), .match_val(match_val),
    .en(en), .wd_mode(wd_mode), .clr(clr)
  );

  wdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .tick(tick_i),
    .match_val(match_val), .cnt(cnt), .hit(hit)
  );

  wdt_event u_evt (
    .clk(clk), .rst(rst), .hit(hit), .wd_mode(wd_mode), .ack(irq_ack_i),
    .irq(irq_o), .rst_req(cpu_rst_req_o)
  );
endmodule

// File: tb/sim_wdog_match_timer.sv
module sim_wdog_match_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       irq_o;
  logic       cpu_rst_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  wdog_match_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
    .irq_ack_i(irq_ack_i), .irq_o(irq_o), .cpu_rst_req_o(cpu_rst_req_o)
  );

  // Monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL read with nothing expected: actual %02h", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", t, act, e);
    end
  endtask

  task automatic ack_pulse();
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_expect(8'h8E, 8'h00, "R1 counter after reset");
    rd_expect(8'h8D, 8'h00, "R1 mode after reset");
    chk(irq_o, 1'b0, "R1 irq after reset");
    chk(cpu_rst_req_o, 1'b0, "R1 reset request after reset");
    // R4 mode register fully read/write
    wr_reg(8'h8D, 8'h9F);
    rd_expect(8'h8D, 8'h9F, "R4 mode readback");
    // R1 default match FFh: flag on the 256th tick
    wr_reg(8'h8D, 8'h80);
    ticks(255);
    chk(irq_o, 1'b0, "R1 no flag before 256th tick");
    rd_expect(8'h8E, 8'hFF, "R4 counter readback at 8Eh");
    ticks(1);
    chk(irq_o, 1'b1, "R1 flag on 256th tick");
    chk(cpu_rst_req_o, 1'b0, "R8 no reset in interval mode");
    rd_expect(8'h8E, 8'h00, "R3 counter wraps on match");
    ack_pulse();
    chk(irq_o, 1'b0, "R7 ack clears flag");
    // R2 counting, match register not readable
    wr_reg(8'h8E, 8'h03);
    ticks(2);
    rd_expect(8'h8E, 8'h02, "R2 counter advances per tick");
    // R5 self-clearing clear bit
    wr_reg(8'h8D, 8'hA0);
    @(negedge clk);
    rd_expect(8'h8D, 8'h80, "R5 clear bit reads 0");
    rd_expect(8'h8E, 8'h00, "R5 counter cleared");
    // R3 interval of match+1 ticks
    ticks(3);
    chk(irq_o, 1'b0, "R3 no flag before match+1 ticks");
    rd_expect(8'h8E, 8'h03, "R3 counter at match value");
    ticks(1);
    chk(irq_o, 1'b1, "R3 flag after match+1 ticks");
    chk(cpu_rst_req_o, 1'b0, "R8 no reset on match");
    // R7 match and ack on the same edge keeps the flag
    ack_pulse();
    ticks(3);
    @(negedge clk); tick_i = 1'b1; irq_ack_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; irq_ack_i = 1'b0;
    chk(irq_o, 1'b1, "R7 match wins over ack");
    ack_pulse();
    chk(irq_o, 1'b0, "R7 ack after collision");
    // R2 disabled counter ignores ticks
    ticks(2);
    wr_reg(8'h8D, 8'h00);
    ticks(5);
    rd_expect(8'h8E, 8'h02, "R2 counter holds when disabled");
    chk(irq_o, 1'b0, "R2 no flag when disabled");
    // R6 clear and tick on the same edge, counter at match value
    wr_reg(8'h8D, 8'h80);
    ticks(1);
    wr_reg(8'h8D, 8'hA0);
    tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk(irq_o, 1'b0, "R6 clear suppresses match");
    rd_expect(8'h8E, 8'h00, "R6 clear wins over tick");
    // R4 unmapped address
    rd_expect(8'h10, 8'h00, "R4 unmapped read");
    // R9 watchdog mode
    wr_reg(8'h8E, 8'h01);
    wr_reg(8'h8D, 8'hE0);
    @(negedge clk);
    ticks(1);
    chk(cpu_rst_req_o, 1'b0, "R9 no reset before match");
    ticks(1);
    chk(cpu_rst_req_o, 1'b1, "R9 reset request on match");
    chk(irq_o, 1'b1, "R9 flag on watchdog match");
    @(negedge clk);
    chk(cpu_rst_req_o, 1'b0, "R9 reset request lasts one cycle");
    ticks(2);
    chk(cpu_rst_req_o, 1'b1, "R9 reset again while flag pending");
    // R3 match value 0 flags on every tick
    wr_reg(8'h8D, 8'h80);
    ack_pulse();
    wr_reg(8'h8E, 8'h00);
    ticks(1);
    chk(irq_o, 1'b1, "R3 match zero flags each tick");
    chk(cpu_rst_req_o, 1'b0, "R8 interval mode after watchdog");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL reads left unchecked: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule